// File: doc/BRIEF.md
# Auto-Reload Buffer-Chain DMA Channel Sequencer

This block sequences a single DMA channel that copies a chain of equal-sized buffers from a source region to a destination region. Software programs the following through a small word-indexed register port:

- a source start address and a destination start address;
- a control word, which holds a beat count, an address mode for each side, an auto-chain flag and two address-reload flags;
- an interrupt mask.

The channel starts when its enable bit is set and the global enable is also on. For every beat it performs one word read followed by one word write over a valid/ready memory port. It then steps each address up or down by one word, or leaves it fixed.

When a buffer ends, the sequencer always restores the beat count. It restores each address to its programmed start value if that side's reload flag is set, and otherwise carries on from where it stopped. If the auto flag is still set, the chain continues. It either stalls for a software keep-on write, when the buffer-complete interrupt is unmasked, or starts the next buffer at once. If software has cleared the auto flag, the buffer that just ended was the last one. The channel then raises transfer-complete and clears its own enable, which software can poll.

Top module: `dma_chain_seq`

## Requirements
- R1: At each buffer end with the auto flag set, the beat count is restored. The source address returns to its programmed value when control bit 17 is 1, and the destination address does the same when control bit 18 is 1. A side whose flag is 0 continues from its next stepped address.
- R2: An idle channel issues no memory request unless both of these bits are 1: register 1 bit 0 (channel enable, set by writing 1) and register 0 bit 0 (global enable).
- R3: Every buffer end sets status bit 0 (buffer complete) in register 6, whether or not that bit is masked.
- R4: With the auto flag set and mask bit 0 (register 5) at 1, the channel stalls after a buffer. While stalled, register 1 bit 1 reads 1 and no memory request is made, until software writes 1 to register 1 bit 1 (keep-on).
- R5: With the auto flag set and mask bit 0 at 0, the next buffer starts straight after the previous one, and the stalled bit never reads 1.
- R6: If control bit 16 (auto) is 0 when a buffer ends, that buffer is the last. Status bit 1 (transfer complete) is set and the channel enable clears.
- R7: Register 1 bit 0 reads 1 from the enable write until the last buffer ends, and 0 after that.
- R8: The source mode is control bits 13:12 and the destination mode is bits 15:14. The codes are 0 for increment by 4, 1 for decrement by 4, and 2 or 3 for fixed. A request that is not yet accepted holds its address and direction.
- R9: The beat count is control bits 11:0. A count of 0 moves exactly one beat.
- R10: Each beat reads the word at the current source address, then writes that same word to the current destination address.
- R11: Status bits are sticky and are cleared by writing 1 to the matching bit of register 6. The irq output is high exactly when a status bit and its mask bit are both 1.
- R12: A keep-on write while the channel is not stalled has no effect: the stalled bit stays 0 and no request is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index (0 global, 1 channel, 2 source, 3 destination, 4 control, 5 mask, 6 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| irq | output | 1 | Masked OR of the interrupt status bits |
| mem_valid | output | 1 | Memory request valid |
| mem_we | output | 1 | 1 = write request, 0 = read request |
| mem_addr | output | 32 | Request byte address |
| mem_wdata | output | 32 | Write data |
| mem_ready | input | 1 | Request accepted in this cycle |
| mem_rdata | input | 32 | Read data, valid in the cycle a read is accepted |

## Verification
The assertions assume the memory returns read data in the same cycle it raises mem_ready for a read. They also assume software never writes the channel-enable bit in the very cycle the final beat is accepted, because a set would override the self-clear. The bench's memory model answers reads combinationally from its array and lets mem_ready drop every third cycle to exercise request holding. It programs the control word only while the channel is idle or stalled, except for the deliberate clearing of the auto flag. It issues enable writes only while the channel is idle.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE  = 2'd0,
      SQ_READ  = 2'd1,
      SQ_WRITE = 2'd2,
      SQ_HOLD  = 2'd3
   } seq_state_e;

   // register indices on the configuration port
   localparam int RIX_GLOBAL = 0;
   localparam int RIX_CHAN   = 1;
   localparam int RIX_SRC    = 2;
   localparam int RIX_DST    = 3;
   localparam int RIX_CTRL   = 4;
   localparam int RIX_MASK   = 5;
   localparam int RIX_STAT   = 6;

   // control word fields above the beat count
   localparam int CF_SMODE = 0;
   localparam int CF_DMODE = 2;
   localparam int CF_AUTO  = 4;
   localparam int CF_SRLD  = 5;
   localparam int CF_DRLD  = 6;
   localparam int CF_EXTRA = 7;
endpackage

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 4
) (
   input  logic [ADDR_W-1:0] cur_i,
   input  logic [1:0]        mode_i,
   output logic [ADDR_W-1:0] nxt_o
);
   always_comb begin
      if (mode_i[1])      nxt_o = cur_i;
      else if (mode_i[0]) nxt_o = cur_i - ADDR_W'(STEP);
      else                nxt_o = cur_i + ADDR_W'(STEP);
   end
endmodule

// File: rtl/dma_seq_regs.sv
module dma_seq_regs
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 12,
   parameter int RA_W   = 3
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      reg_wr,
   input  logic [RA_W-1:0]           reg_addr,
   input  logic [DATA_W-1:0]         reg_wdata,
   output logic [DATA_W-1:0]         reg_rdata,
   input  logic                      stalled_i,
   input  logic                      en_clr_i,
   input  logic                      bc_set_i,
   input  logic                      tc_set_i,
   output logic                      glob_en_o,
   output logic                      ch_en_o,
   output logic                      keepon_o,
   output logic [ADDR_W-1:0]         src_init_o,
   output logic [ADDR_W-1:0]         dst_init_o,
   output logic [CNT_W+CF_EXTRA-1:0] ctrl_o,
   output logic [1:0]                mask_o,
   output logic [1:0]                stat_o,
   output logic                      irq_o
);
   localparam int CTRL_W = CNT_W + CF_EXTRA;

   logic hit_glob, hit_chan, hit_src, hit_dst, hit_ctrl, hit_mask, hit_stat;

   assign hit_glob = reg_wr && (reg_addr == RA_W'(RIX_GLOBAL));
   assign hit_chan = reg_wr && (reg_addr == RA_W'(RIX_CHAN));
   assign hit_src  = reg_wr && (reg_addr == RA_W'(RIX_SRC));
   assign hit_dst  = reg_wr && (reg_addr == RA_W'(RIX_DST));
   assign hit_ctrl = reg_wr && (reg_addr == RA_W'(RIX_CTRL));
   assign hit_mask = reg_wr && (reg_addr == RA_W'(RIX_MASK));
   assign hit_stat = reg_wr && (reg_addr == RA_W'(RIX_STAT));

   assign keepon_o = hit_chan && reg_wdata[1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_en_o  <= 1'b0;
         ch_en_o    <= 1'b0;
         src_init_o <= '0;
         dst_init_o <= '0;
         ctrl_o     <= '0;
         mask_o     <= '0;
         stat_o     <= '0;
      end else begin
         if (hit_glob) glob_en_o <= reg_wdata[0];
         if (en_clr_i) ch_en_o <= 1'b0;
         if (hit_chan && reg_wdata[0]) ch_en_o <= 1'b1;
         if (hit_src)  src_init_o <= reg_wdata[ADDR_W-1:0];
         if (hit_dst)  dst_init_o <= reg_wdata[ADDR_W-1:0];
         if (hit_ctrl) ctrl_o <= reg_wdata[CTRL_W-1:0];
         if (hit_mask) mask_o <= reg_wdata[1:0];
         stat_o <= (stat_o & ~(hit_stat ? reg_wdata[1:0] : 2'b00))
                   | {tc_set_i, bc_set_i};
      end
   end

   assign irq_o = |(stat_o & mask_o);

   always_comb begin
      reg_rdata = '0;
      case (int'(reg_addr))
         RIX_GLOBAL: reg_rdata[0] = glob_en_o;
         RIX_CHAN:   reg_rdata[1:0] = {stalled_i, ch_en_o};
         RIX_SRC:    reg_rdata = DATA_W'(src_init_o);
         RIX_DST:    reg_rdata = DATA_W'(dst_init_o);
         RIX_CTRL:   reg_rdata = DATA_W'(ctrl_o);
         RIX_MASK:   reg_rdata[1:0] = mask_o;
         RIX_STAT:   reg_rdata[1:0] = stat_o;
         default:    reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/dma_seq_fsm.sv
module dma_seq_fsm
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              glob_en_i,
   input  logic              ch_en_i,
   input  logic              keepon_i,
   input  logic [ADDR_W-1:0] src_init_i,
   input  logic [ADDR_W-1:0] dst_init_i,
   input  logic [CNT_W-1:0]  count_i,
   input  logic [1:0]        smode_i,
   input  logic [1:0]        dmode_i,
   input  logic              auto_i,
   input  logic              srld_i,
   input  logic              drld_i,
   input  logic              bc_unmasked_i,
   output logic              mem_valid,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              busy_o,
   output logic              stalled_o,
   output logic              buf_done_o,
   output logic              last_done_o
);
   localparam int STEP = DATA_W / 8;

   seq_state_e        state;
   logic [ADDR_W-1:0] cur   [2];
   logic [ADDR_W-1:0] nxt   [2];
   logic [ADDR_W-1:0] init_a[2];
   logic [1:0]        mode  [2];
   logic              rld   [2];
   logic [CNT_W-1:0]  beats;
   logic [CNT_W-1:0]  first_cnt;
   logic [DATA_W-1:0] data_q;

   assign init_a[0] = src_init_i;
   assign init_a[1] = dst_init_i;
   assign mode[0]   = smode_i;
   assign mode[1]   = dmode_i;
   assign rld[0]    = srld_i;
   assign rld[1]    = drld_i;
   assign first_cnt = (count_i == '0) ? CNT_W'(1) : count_i;

   for (genvar k = 0; k < 2; k++) begin : g_side
      dma_addr_step #(.ADDR_W(ADDR_W), .STEP(STEP)) step_i (
         .cur_i (cur[k]),
         .mode_i(mode[k]),
         .nxt_o (nxt[k])
      );
   end

   assign mem_valid   = (state == SQ_READ) || (state == SQ_WRITE);
   assign mem_we      = (state == SQ_WRITE);
   assign mem_addr    = (state == SQ_WRITE) ? cur[1] : cur[0];
   assign mem_wdata   = data_q;
   assign busy_o      = (state != SQ_IDLE);
   assign stalled_o   = (state == SQ_HOLD);
   assign buf_done_o  = (state == SQ_WRITE) && mem_ready && (beats == CNT_W'(1));
   assign last_done_o = buf_done_o && !auto_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= SQ_IDLE;
         cur[0] <= '0;
         cur[1] <= '0;
         beats  <= '0;
         data_q <= '0;
      end else begin
         case (state)
            SQ_IDLE: if (glob_en_i && ch_en_i) begin
               cur[0] <= src_init_i;
               cur[1] <= dst_init_i;
               beats  <= first_cnt;
               state  <= SQ_READ;
            end
            SQ_READ: if (mem_ready) begin
               data_q <= mem_rdata;
               state  <= SQ_WRITE;
            end
            SQ_WRITE: if (mem_ready) begin
               if (beats == CNT_W'(1)) begin
                  beats <= first_cnt;
                  for (int k = 0; k < 2; k++)
                     cur[k] <= rld[k] ? init_a[k] : nxt[k];
                  if (!auto_i)           state <= SQ_IDLE;
                  else if (bc_unmasked_i) state <= SQ_HOLD;
                  else                   state <= SQ_READ;
               end else begin
                  beats  <= beats - CNT_W'(1);
                  cur[0] <= nxt[0];
                  cur[1] <= nxt[1];
                  state  <= SQ_READ;
               end
            end
            SQ_HOLD: if (keepon_i) state <= SQ_READ;
            default: state <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dma_chain_seq.sv
module dma_chain_seq
   import dma_seq_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 12,
   parameter int RA_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [RA_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   output logic              mem_valid,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ready,
   input  logic [DATA_W-1:0] mem_rdata
);
   localparam int CTRL_W = CNT_W + CF_EXTRA;

   if (DATA_W % 8 != 0 || DATA_W < 16) begin : g_bad_data
      $error("dma_chain_seq: DATA_W must be a multiple of 8, at least 16");
   end
   if (ADDR_W > DATA_W) begin : g_bad_addr
      $error("dma_chain_seq: ADDR_W must not exceed DATA_W");
   end
   if (CTRL_W > DATA_W || CNT_W < 1) begin : g_bad_cnt
      $error("dma_chain_seq: control word does not fit the data width");
   end
   if (RA_W < 3) begin : g_bad_ra
      $error("dma_chain_seq: RA_W must be at least 3");
   end

   logic              glob_en, ch_en, keepon, busy, stalled, buf_done, last_done;
   logic [ADDR_W-1:0] src_init, dst_init;
   logic [CTRL_W-1:0] ctrl;
   logic [1:0]        int_mask, int_stat;
   logic              ctrl_auto;

   assign ctrl_auto = ctrl[CNT_W+CF_AUTO];

   dma_seq_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RA_W(RA_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_wr    (reg_wr),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .stalled_i (stalled),
      .en_clr_i  (last_done),
      .bc_set_i  (buf_done),
      .tc_set_i  (last_done),
      .glob_en_o (glob_en),
      .ch_en_o   (ch_en),
      .keepon_o  (keepon),
      .src_init_o(src_init),
      .dst_init_o(dst_init),
      .ctrl_o    (ctrl),
      .mask_o    (int_mask),
      .stat_o    (int_stat),
      .irq_o     (irq)
   );

   dma_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) fsm_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .glob_en_i    (glob_en),
      .ch_en_i      (ch_en),
      .keepon_i     (keepon),
      .src_init_i   (src_init),
      .dst_init_i   (dst_init),
      .count_i      (ctrl[CNT_W-1:0]),
      .smode_i      (ctrl[CNT_W+CF_SMODE +: 2]),
      .dmode_i      (ctrl[CNT_W+CF_DMODE +: 2]),
      .auto_i       (ctrl_auto),
      .srld_i       (ctrl[CNT_W+CF_SRLD]),
      .drld_i       (ctrl[CNT_W+CF_DRLD]),
      .bc_unmasked_i(int_mask[0]),
      .mem_valid    (mem_valid),
      .mem_we       (mem_we),
      .mem_addr     (mem_addr),
      .mem_wdata    (mem_wdata),
      .mem_ready    (mem_ready),
      .mem_rdata    (mem_rdata),
      .busy_o       (busy),
      .stalled_o    (stalled),
      .buf_done_o   (buf_done),
      .last_done_o  (last_done)
   );
endmodule

// File: rtl/dma_chain_seq_chk.sv
module dma_chain_seq_chk #(
   parameter int ADDR_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy,
   input logic              stalled,
   input logic              keepon,
   input logic              glob_en,
   input logic              ch_en,
   input logic              buf_done,
   input logic              ctrl_auto,
   input logic              en_set_wr,
   input logic [1:0]        int_stat,
   input logic              mem_valid,
   input logic              mem_ready,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr
);
   p_start_gated_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(glob_en && ch_en));

   p_stall_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stalled && !keepon |=> stalled);

   p_stall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      stalled |-> !mem_valid);

   p_bc_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
      buf_done |=> int_stat[0]);

   p_last_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
      buf_done && !ctrl_auto && !en_set_wr |=> !ch_en && int_stat[1] && !busy);

   p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we));

   p_keepon_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !stalled && !busy |=> !stalled);
endmodule

bind dma_chain_seq dma_chain_seq_chk #(.ADDR_W(ADDR_W)) chk_i (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .stalled  (stalled),
   .keepon   (keepon),
   .glob_en  (glob_en),
   .ch_en    (ch_en),
   .buf_done (buf_done),
   .ctrl_auto(ctrl_auto),
   .en_set_wr(reg_wr && (reg_addr == 3'd1) && reg_wdata[0]),
   .int_stat (int_stat),
   .mem_valid(mem_valid),
   .mem_ready(mem_ready),
   .mem_we   (mem_we),
   .mem_addr (mem_addr)
);

// File: tb/dma_chain_seq_tb_top.sv
module dma_chain_seq_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        irq;
   logic        mem_valid, mem_we;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic        mem_ready = 1'b1;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int req_cnt = 0;

   logic [31:0] mem [0:255];
   logic [31:0] em  [0:255];

   always #10 clk = ~clk;

   dma_chain_seq dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata)
   );

   assign mem_rdata = mem[mem_addr[9:2]];

   always @(posedge clk)
      if (mem_valid && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;

   always @(negedge clk) begin
      cyc++;
      mem_ready = (cyc % 3) != 1;
      if (mem_valid) req_cnt++;
   end

   // src[39:28] dst[27:16] count[15:4] smode[3:2] dmode[1:0]
   localparam logic [39:0] VEC [0:5] = '{
      {12'h000, 12'h200, 12'd4, 2'd0, 2'd0},
      {12'h03C, 12'h300, 12'd3, 2'd1, 2'd0},
      {12'h040, 12'h100, 12'd5, 2'd2, 2'd0},
      {12'h080, 12'h180, 12'd0, 2'd0, 2'd0},
      {12'h010, 12'h3F0, 12'd4, 2'd0, 2'd1},
      {12'h020, 12'h2C0, 12'd3, 2'd0, 2'd2}
   };

   function automatic logic [31:0] pat(int i);
      return 32'h5A00_0000 ^ (i * 32'h0001_0307);
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic fill_mem();
      for (int i = 0; i < 256; i++) begin
         mem[i] = pat(i);
         em[i]  = pat(i);
      end
   endtask

   // reference copy for one buffer built from the mode rules
   task automatic model(input int s, input int d, input int n, input int sm, input int dm);
      int beats = (n == 0) ? 1 : n;
      for (int b = 0; b < beats; b++) begin
         int sa = (sm >= 2) ? s : (sm == 1 ? s - 4*b : s + 4*b);
         int da = (dm >= 2) ? d : (dm == 1 ? d - 4*b : d + 4*b);
         em[(da >> 2) & 255] = pat((sa >> 2) & 255);
      end
   endtask

   task automatic cmp_mem(input string tag);
      int bad = 0;
      for (int i = 0; i < 256; i++) if (mem[i] !== em[i]) bad++;
      check(tag, bad, 0);
   endtask

   task automatic wait_idle(input string tag);
      logic [31:0] v;
      int n = 0;
      do begin rd(3'd1, v); n++; end while (v[0] && n < 2000);
      check(tag, v[1:0], 2'b00);
   endtask

   initial begin
      #(20 * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int seen;
      fill_mem();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      rd(3'd1, v); check("R7 reset channel status", v, 0);
      rd(3'd6, v); check("R11 reset status", v, 0);
      check("R11 reset irq", irq, 0);
      check("R2 reset no request", mem_valid, 0);

      // R2: channel enable alone does not start
      wr(3'd2, 32'h000); wr(3'd3, 32'h200); wr(3'd4, 32'd4);
      req_cnt = 0;
      wr(3'd1, 32'h1);
      repeat (20) @(negedge clk);
      check("R2 no request without global enable", req_cnt, 0);
      rd(3'd1, v); check("R7 enable reads 1 while pending", v[0], 1);
      wr(3'd0, 32'h1);
      model(0, 32'h200, 4, 0, 0);
      wait_idle("R7 enable clears after run");
      cmp_mem("R10 copy after global enable");

      // single-buffer vectors covering address modes and zero count
      for (int k = 0; k < 6; k++) begin
         int s  = int'(VEC[k][39:28]);
         int d  = int'(VEC[k][27:16]);
         int n  = int'(VEC[k][15:4]);
         int sm = int'(VEC[k][3:2]);
         int dm = int'(VEC[k][1:0]);
         fill_mem();
         wr(3'd6, 32'h3);
         wr(3'd2, s); wr(3'd3, d);
         wr(3'd4, (dm << 14) | (sm << 12) | n);
         wr(3'd1, 32'h1);
         model(s, d, n, sm, dm);
         wait_idle("R7 vector end");
         cmp_mem($sformatf("R8 R9 R10 vector %0d image", k));
         rd(3'd6, v); check("R6 transfer complete flag", v[1:0], 2'b11);
      end

      // R11: masked irq and write-1 clear
      wr(3'd5, 32'h3);
      check("R11 irq with status and mask", irq, 1);
      wr(3'd6, 32'h1);
      rd(3'd6, v); check("R11 partial clear", v[1:0], 2'b10);
      wr(3'd6, 32'h2);
      check("R11 irq low after clear", irq, 0);

      // R12: keep-on while idle
      req_cnt = 0;
      wr(3'd1, 32'h2);
      repeat (5) @(negedge clk);
      rd(3'd1, v); check("R12 keep-on idle no stall", v[1:0], 0);
      check("R12 keep-on idle no request", req_cnt, 0);

      // R5: auto chain with buffer interrupt masked
      fill_mem();
      wr(3'd5, 32'h0);
      wr(3'd2, 32'h000); wr(3'd3, 32'h200);
      wr(3'd4, (1 << 18) | (1 << 17) | (1 << 16) | 3);
      wr(3'd1, 32'h1);
      seen = 0;
      for (int i = 0; i < 40; i++) begin rd(3'd1, v); if (v[1]) seen++; end
      check("R5 never stalled while masked", seen, 0);
      rd(3'd6, v); check("R3 buffer complete set while masked", v[1:0], 2'b01);
      check("R11 irq low with zero mask", irq, 0);
      wr(3'd4, (1 << 18) | (1 << 17) | 3);
      model(0, 32'h200, 3, 0, 0);
      wait_idle("R6 chain ends after auto cleared");
      cmp_mem("R1 R10 reloaded buffers image");
      rd(3'd6, v); check("R6 transfer complete after chain", v[1], 1);

      // R4 + R1: stall with both reloads, then restart at start address
      fill_mem();
      wr(3'd6, 32'h3);
      wr(3'd5, 32'h1);
      wr(3'd2, 32'h040); wr(3'd3, 32'h380);
      wr(3'd4, (1 << 18) | (1 << 17) | (1 << 16) | 2);
      wr(3'd1, 32'h1);
      seen = 0;
      for (int i = 0; i < 200 && !seen; i++) begin rd(3'd1, v); if (v[1]) seen = 1; end
      check("R4 stalled bit set", seen, 1);
      check("R3 irq on unmasked buffer complete", irq, 1);
      req_cnt = 0;
      repeat (10) @(negedge clk);
      check("R4 no request while stalled", req_cnt, 0);
      rd(3'd1, v); check("R4 still stalled", v[1:0], 2'b11);
      wr(3'd4, (1 << 18) | (1 << 17) | 2);
      wr(3'd1, 32'h2);
      while (!mem_valid) @(negedge clk);
      check("R1 source reloaded after keep-on", mem_addr, 32'h040);
      wait_idle("R6 ends after final buffer");
      rd(3'd6, v); check("R6 R3 both flags after stall run", v[1:0], 2'b11);

      // R1: source reload off continues from stepped address
      fill_mem();
      wr(3'd6, 32'h3);
      wr(3'd4, (1 << 18) | (1 << 16) | 2);
      wr(3'd1, 32'h1);
      seen = 0;
      for (int i = 0; i < 200 && !seen; i++) begin rd(3'd1, v); if (v[1]) seen = 1; end
      check("R4 stall in no-reload run", seen, 1);
      wr(3'd4, (1 << 18) | 2);
      wr(3'd1, 32'h2);
      while (!mem_valid) @(negedge clk);
      check("R1 source continues without reload", mem_addr, 32'h048);
      wait_idle("R7 no-reload run ends");

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule